// File: doc/BRIEF.md
# Prescaled Multi-Channel Down-Counter Timer

This block is a memory-mapped timer peripheral. One shared 16-bit prescaler divides the clock into a common tick. Between one and eight channels each hold a 32-bit down-counter that moves by one on every tick. A channel fires when its counter underflows, which is the tick after the counter has reached zero. On that event the channel can latch a sticky pending flag and pulse its own interrupt line. It can also reload itself from a per-channel reload register and keep running.

Software reaches the block through a plain single-cycle register port. An address, a write strobe and write data are taken at a clock edge. Read data is a combinational function of the address, so it appears in the same cycle. There is no handshake and no back-pressure: every access completes at once. A read-only capability word reports the channel count, the base interrupt number and two fixed feature flags.

Top module: `tick_timer_unit`

## Requirements
- R1: Address decode. Bits [7:4] select a slot and bits [3:2] select a field. Bits [1:0] are ignored. Slot 0 holds the unit registers: prescaler value at 0x00, prescaler reload at 0x04 and capability word at 0x08. Slot n+1 holds channel n: counter at +0x0, reload at +0x4 and control at +0x8.
- R2: The prescaler value and the prescaler reload are 16 bits wide. Write bits [31:16] are dropped, and those bits read as 0.
- R3: The prescaler counts down once per clock. In a cycle where its value is 0 it emits a tick and takes the reload value. The tick period is therefore reload+1 clocks, and a reload of 0 gives a tick on every clock.
- R4: An enabled channel decrements on each tick. On a tick that finds the counter already at 0 it underflows. A channel started with N in its counter underflows on the (N+1)-th tick.
- R5: On underflow with interrupt enable (control bit 3) set, the pending flag (control bit 4) becomes 1. The channel's own `irq` bit is high for exactly one cycle, the cycle after that tick's clock edge. With interrupt enable clear, `irq` stays low and pending is not set.
- R6: Writing control with bit 4 = 1 clears pending. Writing it with bit 4 = 0 leaves pending as it is. Hardware never clears pending.
- R7: Control bit 0 is enable and bit 1 is auto-restart. Bit 2 is a load command: a write with it set copies the channel reload into the counter. Bit 2, bits 5 and 6, and bits [31:5] always read 0.
- R8: On underflow with auto-restart set, the counter takes the reload value and keeps running. Events then repeat every (N+1)*(P+1) clocks, where N is the channel reload and P is the prescaler reload.
- R9: On underflow without auto-restart, the counter becomes all ones and the enable bit clears. No further events occur until software restarts the channel.
- R10: A write to a channel counter replaces its count, and counting continues from the new value while the channel is enabled. A write to a channel's counter or control register in a cycle takes the place of that channel's tick in that cycle.
- R11: The capability word at 0x08 reads as follows: bits [2:0] hold the channel count modulo 8, bits [7:3] hold the base interrupt number, bit 8 is 1 (one interrupt line per channel) and bit 9 is 1 (no freeze support). Writes to it are ignored.
- R12: Field 3 of any slot, and slots above the configured channel count, read 0. Writes to them change nothing.
- R13: After reset the prescaler value and reload, and every channel's counter, reload and control, read 0. All channels are stopped and every `irq` bit is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | NUM_CH | One-cycle event pulse per channel |

## Verification
The hardest part to check from the ports is the exact underflow spacing while the prescaler divides. The prescaler phase at the moment a channel starts is not visible, so the delay to the first event depends on history. To get around this, the stimulus lets an auto-restarting channel fire once to absorb the phase. It then measures the clock count between consecutive `irq` pulses and compares it with (N+1)*(P+1) over a sweep of both reload values. The prescaler sequence itself is checked separately by forcing its value to 0 and reading it back on every clock.

// File: rtl/ttu_pkg.sv
package ttu_pkg;
  localparam int unsigned BUS_W = 32;

  localparam int CTL_RUN     = 0;
  localparam int CTL_RESTART = 1;
  localparam int CTL_LOAD    = 2;
  localparam int CTL_IRQ_EN  = 3;
  localparam int CTL_PEND    = 4;

  typedef enum logic [1:0] {
    FLD_COUNT  = 2'd0,
    FLD_RELOAD = 2'd1,
    FLD_CONF   = 2'd2,
    FLD_HOLE   = 2'd3
  } fld_e;

  typedef struct packed {
    logic pend;
    logic irq_en;
    logic restart;
    logic run;
  } ch_ctl_t;

  function automatic logic [BUS_W-1:0] pack_ctl(input ch_ctl_t c);
    logic [BUS_W-1:0] w;
    w = '0;
    w[CTL_RUN]     = c.run;
    w[CTL_RESTART] = c.restart;
    w[CTL_IRQ_EN]  = c.irq_en;
    w[CTL_PEND]    = c.pend;
    return w;
  endfunction
endpackage

// File: rtl/ttu_decode.sv
module ttu_decode
  import ttu_pkg::*;
#(
  parameter int unsigned NUM_CH = 2
) (
  input  logic [5:0]        word_addr,
  input  logic              we,
  output logic              unit_sel,
  output logic [NUM_CH-1:0] ch_sel,
  output fld_e              fld,
  output logic [NUM_CH-1:0] wr_cnt,
  output logic [NUM_CH-1:0] wr_rld,
  output logic [NUM_CH-1:0] wr_ctl,
  output logic              wr_pre_val,
  output logic              wr_pre_rld
);
  logic [3:0] slot;

  assign slot       = word_addr[5:2];
  assign fld        = fld_e'(word_addr[1:0]);
  assign unit_sel   = (slot == 4'd0);
  assign wr_pre_val = we && unit_sel && (fld == FLD_COUNT);
  assign wr_pre_rld = we && unit_sel && (fld == FLD_RELOAD);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign ch_sel[i] = (slot == 4'(i + 1));
    assign wr_cnt[i] = we && ch_sel[i] && (fld == FLD_COUNT);
    assign wr_rld[i] = we && ch_sel[i] && (fld == FLD_RELOAD);
    assign wr_ctl[i] = we && ch_sel[i] && (fld == FLD_CONF);
  end
endmodule

// File: rtl/ttu_prescaler.sv
module ttu_prescaler #(
  parameter int unsigned PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_val,
  input  logic             wr_rld,
  input  logic [PRE_W-1:0] wdata,
  output logic [PRE_W-1:0] value,
  output logic [PRE_W-1:0] reload,
  output logic             tick
);
  assign tick = (value == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value  <= '0;
      reload <= '0;
    end else begin
      if (wr_rld) reload <= wdata;
      if (wr_val)    value <= wdata;
      else if (tick) value <= reload;
      else           value <= value - 1'b1;
    end
  end
endmodule

// File: rtl/ttu_channel.sv
module ttu_channel
  import ttu_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_cnt,
  input  logic             wr_rld,
  input  logic             wr_ctl,
  input  logic [CNT_W-1:0] wdata,
  input  fld_e             fld,
  output logic [CNT_W-1:0] rdata,
  output logic             irq
);
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] reload;
  ch_ctl_t          ctl;
  logic             step;
  logic             at_zero;

  assign step    = tick && ctl.run && !wr_cnt && !wr_ctl;
  assign at_zero = (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      reload <= '0;
      ctl    <= '0;
      irq    <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (wr_rld) reload <= wdata;
      if (wr_ctl) begin
        ctl.run     <= wdata[CTL_RUN];
        ctl.restart <= wdata[CTL_RESTART];
        ctl.irq_en  <= wdata[CTL_IRQ_EN];
        if (wdata[CTL_PEND]) ctl.pend <= 1'b0;
        if (wdata[CTL_LOAD]) count <= reload;
      end else if (wr_cnt) begin
        count <= wdata;
      end else if (step) begin
        if (at_zero) begin
          if (ctl.irq_en) begin
            ctl.pend <= 1'b1;
            irq      <= 1'b1;
          end
          if (ctl.restart) begin
            count <= reload;
          end else begin
            count   <= '1;
            ctl.run <= 1'b0;
          end
        end else begin
          count <= count - 1'b1;
        end
      end
    end
  end

  always_comb begin
    unique case (fld)
      FLD_COUNT:  rdata = count;
      FLD_RELOAD: rdata = reload;
      FLD_CONF:   rdata = CNT_W'(pack_ctl(ctl));
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/tick_timer_unit.sv
module tick_timer_unit
  import ttu_pkg::*;
#(
  parameter int unsigned NUM_CH   = 2,
  parameter int unsigned IRQ_BASE = 8,
  parameter int unsigned PRE_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam logic [31:0] CAPS = 32'((1 << 9) | (1 << 8) |
                                     ((IRQ_BASE % 32) << 3) | (NUM_CH % 8));

  logic              unit_sel;
  logic [NUM_CH-1:0] ch_sel;
  fld_e              fld;
  logic [NUM_CH-1:0] wr_cnt, wr_rld, wr_ctl;
  logic              wr_pre_val, wr_pre_rld;
  logic [PRE_W-1:0]  pre_val, pre_rld;
  logic              pre_tick;
  logic [31:0]       ch_rd [NUM_CH];
  logic              unused_addr_lsb;

  assign unused_addr_lsb = ^bus_addr[1:0];

  ttu_decode #(.NUM_CH(NUM_CH)) u_decode (
    .word_addr  (bus_addr[7:2]),
    .we         (bus_we),
    .unit_sel   (unit_sel),
    .ch_sel     (ch_sel),
    .fld        (fld),
    .wr_cnt     (wr_cnt),
    .wr_rld     (wr_rld),
    .wr_ctl     (wr_ctl),
    .wr_pre_val (wr_pre_val),
    .wr_pre_rld (wr_pre_rld)
  );

  ttu_prescaler #(.PRE_W(PRE_W)) u_prescaler (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_val (wr_pre_val),
    .wr_rld (wr_pre_rld),
    .wdata  (bus_wdata[PRE_W-1:0]),
    .value  (pre_val),
    .reload (pre_rld),
    .tick   (pre_tick)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    ttu_channel #(.CNT_W(32)) u_channel (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (pre_tick),
      .wr_cnt (wr_cnt[i]),
      .wr_rld (wr_rld[i]),
      .wr_ctl (wr_ctl[i]),
      .wdata  (bus_wdata),
      .fld    (fld),
      .rdata  (ch_rd[i]),
      .irq    (irq[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (unit_sel) begin
      unique case (fld)
        FLD_COUNT:  bus_rdata = 32'(pre_val);
        FLD_RELOAD: bus_rdata = 32'(pre_rld);
        FLD_CONF:   bus_rdata = CAPS;
        default:    bus_rdata = '0;
      endcase
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_sel[i]) bus_rdata = ch_rd[i];
    end
  end
endmodule

// File: rtl/ttu_checker.sv
module ttu_checker #(
  parameter int unsigned NUM_CH   = 2,
  parameter int unsigned IRQ_BASE = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        bus_addr,
  input logic [31:0]       bus_rdata,
  input logic [NUM_CH-1:0] irq,
  input logic              tick
);
  localparam logic [31:0] CAPS_EXP = 32'((1 << 9) | (1 << 8) |
                                         ((IRQ_BASE % 32) << 3) | (NUM_CH % 8));

  AST_CAPS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[7:2] == 6'h02) |-> (bus_rdata == CAPS_EXP)); // R11

  AST_PRESCALE_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[7:3] == 5'h00) |-> (bus_rdata[31:16] == 16'h0)); // R2

  AST_CTL_LOAD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[7:4] != 4'h0 && bus_addr[3:2] == 2'd2) |->
      (bus_rdata[2] == 1'b0 && bus_rdata[31:5] == 27'h0)); // R7

  AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[3:2] == 2'd3) |-> (bus_rdata == 32'h0)); // R12

  AST_SLOT_BEYOND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(bus_addr[7:4]) > NUM_CH) |-> (bus_rdata == 32'h0)); // R12

  for (genvar i = 0; i < NUM_CH; i++) begin : g_irq
    AST_IRQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> $past(tick)); // R4
  end
endmodule

bind tick_timer_unit ttu_checker #(.NUM_CH(NUM_CH), .IRQ_BASE(IRQ_BASE)) u_ttu_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .tick      (pre_tick)
);

// File: tb/test_tick_timer_unit.sv
`timescale 1ns/1ps
module test_tick_timer_unit;
  localparam int NCH  = 3;
  localparam int IBASE = 5;
  localparam logic [31:0] EN = 32'h01, RS = 32'h02, LD = 32'h04, IE = 32'h08, IP = 32'h10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [7:0]     bus_addr = '0;
  logic           bus_we = 1'b0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [NCH-1:0] irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tick_timer_unit #(.NUM_CH(NCH), .IRQ_BASE(IBASE)) i_tick_timer_unit (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_irq(input int ch, input int lim, output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!irq[ch] && k < lim);
  endtask

  function automatic logic [7:0] cb(input int ch, input int f);
    return 8'(16 * (ch + 1) + 4 * f);
  endfunction

  initial begin
    logic [31:0] v;
    int k;
    int quiet;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R13 reset state
    chk("R13 irq", 32'(irq), 0);
    rd(8'h00, v); chk("R13 prescaler value", v, 0);
    rd(8'h04, v); chk("R13 prescaler reload", v, 0);
    for (int c = 0; c < NCH; c++)
      for (int f = 0; f < 3; f++) begin
        rd(cb(c, f), v); chk("R13 channel reg", v, 0);
      end

    // R11 capability word, writes ignored
    rd(8'h08, v); chk("R11 caps", v, 32'd811);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, v); chk("R11 caps after write", v, 32'd811);

    // R2 16-bit prescaler registers
    wr(8'h04, 32'hABCD_FFFF);
    rd(8'h04, v); chk("R2 reload masked", v, 32'h0000_FFFF);
    wr(8'h00, 32'h7777_FFF0);
    rd(8'h00, v); chk("R2 value masked", v, 32'h0000_FFF0);

    // R3 prescaler sequence for several reload values
    for (int p = 0; p <= 3; p++) begin
      wr(8'h04, 32'(p));
      wr(8'h00, 32'h0);
      for (int kk = 0; kk <= 2 * p + 2; kk++) begin
        if (kk > 0) @(negedge clk);
        rd(8'h00, v);
        chk("R3 prescaler count", v, 32'((p + 1 - (kk % (p + 1))) % (p + 1)));
      end
    end
    wr(8'h04, 32'h0);
    wr(8'h00, 32'h0);

    // R1 per-channel placement and ignored low address bits
    for (int c = 0; c < NCH; c++) wr(cb(c, 1), 32'h100 * (c + 1));
    for (int c = 0; c < NCH; c++) begin
      rd(cb(c, 1), v); chk("R1 channel reload", v, 32'h100 * (c + 1));
      rd(cb(c, 1) + 8'd2, v); chk("R1 low bits ignored", v, 32'h100 * (c + 1));
    end

    // R4 / R5 / R9 / R6 single-shot latency with tick every clock
    for (int n = 0; n <= 4; n++) begin
      int c;
      c = n % NCH;
      wr(cb(c, 1), 32'(n));
      wr(cb(c, 2), EN | LD | IE);
      wait_irq(c, 100, k);
      chk("R4 underflow latency", 32'(k), 32'(n + 1));
      @(negedge clk);
      chk("R5 irq one cycle", 32'(irq[c]), 0);
      rd(cb(c, 2), v); chk("R9 stopped with pending", v, IE | IP);
      rd(cb(c, 0), v); chk("R9 counter all ones", v, 32'hFFFF_FFFF);
      quiet = 0;
      repeat (10) begin @(negedge clk); if (irq[c]) quiet++; end
      chk("R9 no further events", 32'(quiet), 0);
      wr(cb(c, 2), IE);
      rd(cb(c, 2), v); chk("R6 write 0 keeps pending", v, IE | IP);
      wr(cb(c, 2), IP);
      rd(cb(c, 2), v); chk("R6 write 1 clears", v, 0);
    end

    // R8 auto-restart period sweep
    for (int p = 0; p <= 3; p++)
      for (int ni = 0; ni < 3; ni++) begin
        int n;
        n = (ni == 2) ? 3 : ni;
        wr(8'h04, 32'(p));
        wr(cb(1, 1), 32'(n));
        wr(cb(1, 2), EN | RS | LD | IE);
        wait_irq(1, 200, k);
        for (int rep = 0; rep < 2; rep++) begin
          wait_irq(1, 200, k);
          chk("R8 restart period", 32'(k), 32'((n + 1) * (p + 1)));
        end
        if ((n + 1) * (p + 1) > 1) begin
          @(negedge clk);
          chk("R5 pulse width", 32'(irq[1]), 0);
        end
        rd(cb(1, 2), v); chk("R6 pending held while running", v, EN | RS | IE | IP);
        wr(cb(1, 2), IP);
      end
    wr(8'h04, 32'h0);

    // R5 interrupt enable clear: no pulse, no pending
    wr(cb(2, 1), 32'd2);
    wr(cb(2, 2), EN | RS | LD);
    quiet = 0;
    repeat (20) begin @(negedge clk); if (irq[2]) quiet++; end
    chk("R5 no irq without enable", 32'(quiet), 0);
    rd(cb(2, 2), v); chk("R5 no pending without enable", v, EN | RS);
    rd(cb(2, 0), v); chk("R8 count stays within reload", 32'(v <= 2), 1);
    wr(cb(2, 2), 32'h0);

    // R10 counter write while running and while stopped
    wr(cb(0, 1), 32'd50);
    wr(cb(0, 2), EN | LD | IE);
    repeat (5) @(negedge clk);
    wr(cb(0, 0), 32'd3);
    wait_irq(0, 100, k);
    chk("R10 new count latency", 32'(k), 32'd4);
    wr(cb(0, 2), IP);
    wr(cb(2, 0), 32'd7);
    repeat (5) @(negedge clk);
    rd(cb(2, 0), v); chk("R10 stopped counter holds", v, 32'd7);

    // R7 load command copies reload, reads back as zero
    wr(cb(2, 1), 32'h1234);
    wr(cb(2, 2), 32'h6C);
    rd(cb(2, 2), v); chk("R7 control readback", v, IE);
    rd(cb(2, 0), v); chk("R7 load copied reload", v, 32'h1234);
    wr(cb(2, 2), 32'h0);

    // R12 unmapped reads and writes
    rd(8'h0C, v); chk("R12 unit hole", v, 0);
    rd(8'h1C, v); chk("R12 channel hole", v, 0);
    rd(8'h40, v); chk("R12 absent channel", v, 0);
    rd(8'hF8, v); chk("R12 high slot", v, 0);
    wr(8'h44, 32'hDEAD_BEEF);
    wr(8'h1C, 32'hDEAD_BEEF);
    rd(8'h44, v); chk("R12 absent channel after write", v, 0);
    rd(cb(0, 1), v); chk("R12 ch0 reload untouched", v, 32'd50);
    rd(cb(1, 1), v); chk("R12 ch1 reload untouched", v, 32'd3);
    rd(cb(2, 1), v); chk("R12 ch2 reload untouched", v, 32'h1234);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule